// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block gathers one-cycle event pulses from a USB device controller and turns them into three CPU interrupt requests. One request is for a detected bus reset, one is for a received start-of-frame, and one combined device request covers sixteen finer-grained sources. Each source is held in a sticky status bit. Firmware reads these bits to learn which event fired, and clears them by writing ones.

The sixteen device sources are grouped as follows. The control endpoint has five causes. Each of the three data endpoints has three causes. Suspend and resume have one source each. Every device source sits behind its own enable bit, and the combined request is raised while any source is both enabled and set. The bus reset and start-of-frame requests have no enable: each follows its own sticky status bit directly.

Firmware reaches the block through a small register bus with three word addresses. It can read device status, read or write device enables, and read bus status. Detecting the bus conditions themselves, handling packets and managing buffers are done elsewhere.

Top module: `usbirq_agg`

## Requirements
- R1: After a synchronous reset, all device status bits, all enable bits, both bus status bits, all three interrupt outputs and the read data are 0.
- R2: An event pulse on a device source sets its status bit at the next clock edge. That bit is returned by a read of address 0, at the bit index given in R8.
- R3: A status bit stays set until firmware writes a 1 to that bit position at its address (0 for device status, 2 for bus status). Writing a 0 leaves the bit unchanged.
- R4: When a source's event pulse and a clearing write to the same bit occur in the same cycle, the bit ends up set.
- R5: A write to address 1 loads the sixteen enable bits. A read of address 1 returns them. The enable bits change only through such writes.
- R6: `irq_dev` is 1 exactly when some device status bit and its matching enable bit are both 1, delayed by one cycle. It follows any change of status or enable one clock edge later.
- R7: A pulse on `bus_reset_evt` sets bit 0 of address 2, and a pulse on `sof_evt` sets bit 1 of address 2. `irq_bus_reset` and `irq_sof` equal those two bits in the same cycle. Neither is affected by the device enables.
- R8: Device status and enable bit map:
  - bits 0 to 4 are `ep0_evt[0..4]`, in the order buffer ready, control transfer done, entry to status stage, setup data ready, control error;
  - bits 5+3k to 7+3k are `epn_evt[3k..3k+2]` for data endpoint k+1 (k = 0, 1, 2), in the order buffer 0 ready, buffer 1 ready, transfer error;
  - bit 14 is suspend;
  - bit 15 is resume.
- R9: Read data is registered: `bus_rdata` shows the addressed register one cycle after `bus_rd` and holds its value otherwise. Address 3 reads as 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| ep0_evt | input | 5 | Control endpoint event pulses |
| epn_evt | input | 3*NUM_EPN | Data endpoint event pulses, three per endpoint |
| suspend_evt | input | 1 | Suspend detected pulse |
| resume_evt | input | 1 | Resume detected pulse |
| bus_reset_evt | input | 1 | Bus reset detected pulse |
| sof_evt | input | 1 | Start-of-frame received pulse |
| irq_bus_reset | output | 1 | Bus reset interrupt request |
| irq_sof | output | 1 | Start-of-frame interrupt request |
| irq_dev | output | 1 | Combined device interrupt request |

## Verification
The bench builds the block with its defaults: three data endpoints, a 16-bit data word and a 2-bit address. With these values the whole device map is exactly sixteen bits wide, and every register address, including the unused one, can be reached. This makes it practical to sweep a one-hot pattern across all sixteen sources. For each source the bench checks the bit position, the masking against its own enable and against all other enables, clearing, and the set-beats-clear collision. Expected words are formed arithmetically as shifted ones.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int EP0_CAUSES   = 5;
  localparam int EPN_CAUSES   = 3;
  localparam int REG_DEV_STAT = 0;
  localparam int REG_DEV_EN   = 1;
  localparam int REG_BUS_STAT = 2;
  localparam int BUS_SRCS     = 2;
endpackage

// File: rtl/usbirq_latch_bank.sv
module usbirq_latch_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             q_o[b] <= 1'b0;
      else if (set_i[b])   q_o[b] <= 1'b1;
      else if (clr_i[b])   q_o[b] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> q_o[b]); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (!set_i[b] && clr_i[b]) |=> !q_o[b]); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!set_i[b] && !clr_i[b]) |=> $stable(q_o[b])); // R3
  end
endmodule

// File: rtl/usbirq_regif.sv
module usbirq_regif
  import usbirq_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16,
  parameter int DEV_SRCS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [DEV_SRCS-1:0] dev_st,
  input  logic [BUS_SRCS-1:0] bus_st,
  output logic [DEV_SRCS-1:0] dev_clr,
  output logic [BUS_SRCS-1:0] bus_clr,
  output logic [DEV_SRCS-1:0] dev_en
);
  logic hit_dst, hit_den, hit_bst;
  logic wr_den;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit_dst = (bus_addr == ADDR_W'(REG_DEV_STAT));
    hit_den = (bus_addr == ADDR_W'(REG_DEV_EN));
    hit_bst = (bus_addr == ADDR_W'(REG_BUS_STAT));
    wr_den  = bus_wr && hit_den;
    dev_clr = (bus_wr && hit_dst) ? bus_wdata[DEV_SRCS-1:0] : '0;
    bus_clr = (bus_wr && hit_bst) ? bus_wdata[BUS_SRCS-1:0] : '0;
    rd_mux  = '0;
    if (hit_dst)      rd_mux[DEV_SRCS-1:0] = dev_st;
    else if (hit_den) rd_mux[DEV_SRCS-1:0] = dev_en;
    else if (hit_bst) rd_mux[BUS_SRCS-1:0] = bus_st;
  end

  always_ff @(posedge clk) begin
    if (rst)         dev_en <= '0;
    else if (wr_den) dev_en <= bus_wdata[DEV_SRCS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_den |=> $stable(dev_en)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

// File: rtl/usbirq_mask_or.sv
module usbirq_mask_or #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic any_live;

  always_comb any_live = |(st_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= any_live;
  end

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|st_i)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|en_i)); // R6
endmodule

// File: rtl/usbirq_agg.sv
module usbirq_agg
  import usbirq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16,
  parameter int NUM_EPN = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic                            bus_rd,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [EP0_CAUSES-1:0]           ep0_evt,
  input  logic [EPN_CAUSES*NUM_EPN-1:0]   epn_evt,
  input  logic                            suspend_evt,
  input  logic                            resume_evt,
  input  logic                            bus_reset_evt,
  input  logic                            sof_evt,
  output logic                            irq_bus_reset,
  output logic                            irq_sof,
  output logic                            irq_dev
);
  localparam int DEV_SRCS = EP0_CAUSES + EPN_CAUSES * NUM_EPN + 2;

  logic [DEV_SRCS-1:0] dev_set, dev_clr, dev_st, dev_en;
  logic [BUS_SRCS-1:0] bus_set, bus_clr, bus_st;

  initial begin
    AST_MAP_FITS: assert (DATA_W >= DEV_SRCS); // R8
  end

  always_comb begin
    dev_set = {resume_evt, suspend_evt, epn_evt, ep0_evt};
    bus_set = {sof_evt, bus_reset_evt};
  end

  usbirq_latch_bank #(.W(DEV_SRCS)) u_dev_bank (
    .clk(clk), .rst(rst), .set_i(dev_set), .clr_i(dev_clr), .q_o(dev_st));

  usbirq_latch_bank #(.W(BUS_SRCS)) u_bus_bank (
    .clk(clk), .rst(rst), .set_i(bus_set), .clr_i(bus_clr), .q_o(bus_st));

  usbirq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_SRCS(DEV_SRCS)) u_regif (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_st(dev_st), .bus_st(bus_st), .dev_clr(dev_clr), .bus_clr(bus_clr),
    .dev_en(dev_en));

  usbirq_mask_or #(.W(DEV_SRCS)) u_dev_or (
    .clk(clk), .rst(rst), .st_i(dev_st), .en_i(dev_en), .irq_o(irq_dev));

  always_comb begin
    irq_bus_reset = bus_st[0];
    irq_sof       = bus_st[1];
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!irq_dev && !irq_bus_reset && !irq_sof)); // R1
  AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_bus_reset) |-> $past(bus_reset_evt)); // R7
  AST_SOF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sof) |-> $past(sof_evt)); // R7
endmodule

// File: tb/test_usbirq_agg.sv
`timescale 1ns/1ps
module test_usbirq_agg;
  logic        clk = 0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic [4:0]  ep0_evt;
  logic [8:0]  epn_evt;
  logic        suspend_evt, resume_evt, bus_reset_evt, sof_evt;
  logic        irq_bus_reset, irq_sof, irq_dev;
  logic [15:0] dev_v;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    ep0_evt     = dev_v[4:0];
    epn_evt     = dev_v[13:5];
    suspend_evt = dev_v[14];
    resume_evt  = dev_v[15];
  end

  usbirq_agg i_usbirq_agg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ep0_evt(ep0_evt), .epn_evt(epn_evt), .suspend_evt(suspend_evt),
    .resume_evt(resume_evt), .bus_reset_evt(bus_reset_evt), .sof_evt(sof_evt),
    .irq_bus_reset(irq_bus_reset), .irq_sof(irq_sof), .irq_dev(irq_dev));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse_dev(input logic [15:0] v);
    @(negedge clk); dev_v = v;
    @(negedge clk); dev_v = '0;
  endtask

  initial begin
    logic [15:0] r;
    rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    dev_v = 0; bus_reset_evt = 0; sof_evt = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 irqs", {13'd0, irq_dev, irq_sof, irq_bus_reset}, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    rd(2'd0, r); check("R1 dev status", r, 16'h0);
    rd(2'd1, r); check("R1 enables", r, 16'h0);
    rd(2'd2, r); check("R1 bus status", r, 16'h0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] m;
      m = 16'(1) << i;
      wr(2'd1, m);
      rd(2'd1, r); check("R5 enable readback", r, m);
      pulse_dev(m);
      // R2 / R8: bit position of source i
      rd(2'd0, r); check("R2 R8 status bit", r, m);
      check("R6 irq with own enable", {15'd0, irq_dev}, 16'd1);
      wr(2'd1, ~m);
      @(negedge clk);
      check("R6 irq masked by other enables", {15'd0, irq_dev}, 16'd0);
      wr(2'd0, 16'h0);
      rd(2'd0, r); check("R3 write 0 keeps bit", r, m);
      // R4: event and clear in the same cycle
      @(negedge clk); dev_v = m; bus_addr = 2'd0; bus_wdata = m; bus_wr = 1;
      @(negedge clk); dev_v = 0; bus_wr = 0;
      rd(2'd0, r); check("R4 set wins", r, m);
      wr(2'd0, m);
      rd(2'd0, r); check("R3 write 1 clears", r, 16'h0);
      @(negedge clk);
      check("R6 irq drops after clear", {15'd0, irq_dev}, 16'd0);
    end

    // R6: several sources, enable only one at a time
    wr(2'd1, 16'h0);
    pulse_dev(16'hA5C3);
    rd(2'd0, r); check("R2 multi pattern", r, 16'hA5C3);
    check("R6 no enable no irq", {15'd0, irq_dev}, 16'd0);
    wr(2'd1, 16'h5A3C);
    @(negedge clk);
    check("R6 disjoint enables", {15'd0, irq_dev}, 16'd0);
    wr(2'd1, 16'h0100);
    @(negedge clk);
    check("R6 overlap enable", {15'd0, irq_dev}, 16'd1);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, r); check("R3 clear all", r, 16'h0);

    // R7: bus reset and SOF
    wr(2'd1, 16'hFFFF);
    @(negedge clk); bus_reset_evt = 1;
    @(negedge clk); bus_reset_evt = 0;
    check("R7 bus reset irq", {14'd0, irq_sof, irq_bus_reset}, 16'h1);
    check("R7 no dev irq", {15'd0, irq_dev}, 16'd0);
    @(negedge clk); sof_evt = 1;
    @(negedge clk); sof_evt = 0;
    rd(2'd2, r); check("R7 bus status", r, 16'h3);
    wr(2'd2, 16'h1);
    rd(2'd2, r); check("R7 R3 clear bus reset", r, 16'h2);
    check("R7 sof stays", {14'd0, irq_sof, irq_bus_reset}, 16'h2);
    wr(2'd2, 16'h2);
    check("R7 sof cleared", {15'd0, irq_sof}, 16'd0);

    // R9: unused address and registered read
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, r); check("R9 addr 3 reads 0", r, 16'h0);
    rd(2'd1, r); check("R9 addr 3 write ignored", r, 16'h1234);
    @(negedge clk); bus_addr = 2'd3;
    @(negedge clk);
    check("R9 rdata holds without rd", bus_rdata, 16'h1234);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule